// File: doc/BRIEF.md
# Duty-Cycled Link Controller with Repeated Request-to-Send

This controller decides when a low-power radio listens, sleeps and sends control frames, and it runs a four-frame handshake on its own. While nothing is queued, it turns the receiver on for a short window once per wake period and sleeps for the rest of the period. When a transmit request appears, it carrier-senses for one window. If the channel stays clear, it keeps sending request-to-send frames, each followed by a short listen and a sleep gap, until a clear-to-send reply arrives from a peer that is also duty-cycling. It then sends its data frame and waits for the acknowledgement.

The same controller also plays the receiving role. A request-to-send that arrives during a listen window is answered with a clear-to-send. A data frame that follows is answered with an acknowledgement.

All window lengths, the retry bound and the reply timeout arrive as configuration inputs and are counted in strobes of `tick_i`. Frame contents, modulation and routing are handled elsewhere. The controller only asks for a frame of a given kind through `send_valid_o` and `send_type_o`, and it learns what was received through `rx_valid_i` and `rx_type_i`.

Top module: `tx_init_mac`

## Requirements
- R1: While `rst_ni` is low, `radio_en_o`, `send_valid_o`, `done_o` and `fail_o` are all 0. After reset the controller starts in its sleep phase of `cfg_period_i - cfg_on_i` ticks.
- R2: With `tx_req_i` low, the controller repeats this cycle: `radio_en_o` is high for `cfg_on_i` ticks, then low for `cfg_period_i - cfg_on_i` ticks.
- R3: When `tx_req_i` is high during a sleep or listen phase, the radio turns on on the next cycle for a carrier-sense window of `cfg_on_i` ticks. If `busy_i` stays low for the whole window, a request-to-send follows on the next cycle.
- R4: If `busy_i` is high in any cycle of the carrier-sense window, `radio_en_o` goes low on the next cycle for `cfg_period_i - cfg_on_i` ticks. Carrier sense then starts again if `tx_req_i` is still high.
- R5: A request-to-send is a one-cycle `send_valid_o` pulse with `send_type_o` = 0. It is followed by a listen of `cfg_listen_i` ticks with the radio on, then a gap of `cfg_gap_i` ticks with the radio off, then the next request-to-send.
- R6: Once `cfg_max_rts_i` request-to-send frames have gone out with no reply, the controller gives a one-cycle `fail_o` pulse at the end of the last gap and returns to the sleep phase.
- R7: A clear-to-send (`rx_type_i` = 1 with `rx_valid_i`) received during a post-request listen causes a one-cycle send of DATA (`send_type_o` = 2) on the next cycle.
- R8: An acknowledgement (`rx_type_i` = 3) received within `cfg_timeout_i` ticks after DATA causes a one-cycle `done_o` pulse on the next cycle, followed by the sleep phase.
- R9: If no acknowledgement arrives within `cfg_timeout_i` ticks after DATA, `fail_o` pulses for one cycle and the controller returns to the sleep phase.
- R10: A request-to-send (`rx_type_i` = 0) received during an idle listen window is answered on the next cycle with a clear-to-send (`send_type_o` = 1). A DATA frame (`rx_type_i` = 2) received within `cfg_timeout_i` ticks after that is answered with an acknowledgement (`send_type_o` = 3).
- R11: If no DATA arrives within `cfg_timeout_i` ticks after a clear-to-send, no acknowledgement is sent and the radio goes off for the sleep phase.
- R12: Frames received while the radio is off in the sleep phase cause no frame to be sent.
- R13: At most one of `send_valid_o`, `done_o` and `fail_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe, one cycle wide |
| busy_i | input | 1 | Channel activity detected |
| tx_req_i | input | 1 | A frame is waiting to be sent (level) |
| rx_valid_i | input | 1 | A frame of kind `rx_type_i` was received this cycle |
| rx_type_i | input | 2 | Received kind: 0 RTS, 1 CTS, 2 DATA, 3 ACK |
| cfg_period_i | input | TW | Wake period in ticks |
| cfg_on_i | input | TW | Listen and carrier-sense window in ticks |
| cfg_listen_i | input | TW | Listen after each request-to-send, in ticks |
| cfg_gap_i | input | TW | Radio-off gap between request-to-send frames, in ticks |
| cfg_max_rts_i | input | RW | Maximum request-to-send frames per attempt |
| cfg_timeout_i | input | TW | Reply timeout in ticks |
| radio_en_o | output | 1 | Radio powered |
| send_valid_o | output | 1 | Send one frame of kind `send_type_o` |
| send_type_o | output | 2 | Kind to send, same coding as `rx_type_i` |
| done_o | output | 1 | Exchange acknowledged (pulse) |
| fail_o | output | 1 | Retry limit reached or acknowledgement timeout (pulse) |

## Verification
The bench sets TW to 8 and RW to 4 and drives a tick every second cycle. It uses a 6-tick period, a 2-tick window, a 2-tick post-request listen, a 3-tick gap, a limit of three request-to-send frames and a 4-tick timeout. With values this small, every phase boundary, the full retry run that ends in failure, both reply timeouts and a deferral all happen within a few hundred cycles. Each of these can then be compared cycle by cycle against the reference model.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [3:0] {
    ST_SLEEP, ST_LISTEN, ST_SENSE, ST_DEFER,
    ST_TX_RTS, ST_RTS_WAIT, ST_RTS_GAP, ST_TX_DATA, ST_ACK_WAIT,
    ST_TX_CTS, ST_DATA_WAIT, ST_TX_ACK,
    ST_DONE, ST_FAIL
  } mac_state_e;

  typedef enum logic [1:0] {
    FR_RTS  = 2'd0,
    FR_CTS  = 2'd1,
    FR_DATA = 2'd2,
    FR_ACK  = 2'd3
  } frame_e;
endpackage

// File: rtl/mac_tick_timer.sv
`timescale 1ns/1ps
module mac_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          expire_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + TW'(1);
  end

  // fires on the limit-th tick since the phase began
  assign expire_o = tick_i && (cnt_q == limit_i - TW'(1));
endmodule

// File: rtl/mac_rts_counter.sv
`timescale 1ns/1ps
module mac_rts_counter #(
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [RW-1:0] max_i,
  output logic          reached_o
);
  localparam logic [RW-1:0] CNT_TOP = '1;
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i)                     cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_TOP) cnt_q <= cnt_q + RW'(1);
  end

  assign reached_o = (cnt_q >= max_i);
endmodule

// File: rtl/mac_window_sel.sv
`timescale 1ns/1ps
module mac_window_sel
  import mac_pkg::*;
#(
  parameter int TW = 16
) (
  input  mac_state_e    state_i,
  input  logic [TW-1:0] period_i,
  input  logic [TW-1:0] on_i,
  input  logic [TW-1:0] listen_i,
  input  logic [TW-1:0] gap_i,
  input  logic [TW-1:0] timeout_i,
  output logic [TW-1:0] limit_o
);
  always_comb begin
    unique case (state_i)
      ST_SLEEP, ST_DEFER:          limit_o = period_i - on_i;
      ST_LISTEN, ST_SENSE:         limit_o = on_i;
      ST_RTS_WAIT:                 limit_o = listen_i;
      ST_RTS_GAP:                  limit_o = gap_i;
      ST_ACK_WAIT, ST_DATA_WAIT:   limit_o = timeout_i;
      default:                     limit_o = TW'(1);
    endcase
  end
endmodule

// File: rtl/mac_fsm.sv
`timescale 1ns/1ps
module mac_fsm
  import mac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       expire_i,
  input  logic       tx_req_i,
  input  logic       busy_i,
  input  logic       rx_valid_i,
  input  logic [1:0] rx_type_i,
  input  logic       rts_reached_i,
  output mac_state_e state_o,
  output logic       timer_clr_o,
  output logic       rts_clr_o,
  output logic       rts_inc_o
);
  mac_state_e state_q, state_d;
  logic got_rts, got_cts, got_data, got_ack;

  assign got_rts  = rx_valid_i && (rx_type_i == FR_RTS);
  assign got_cts  = rx_valid_i && (rx_type_i == FR_CTS);
  assign got_data = rx_valid_i && (rx_type_i == FR_DATA);
  assign got_ack  = rx_valid_i && (rx_type_i == FR_ACK);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP:     if (tx_req_i) state_d = ST_SENSE;
                    else if (expire_i) state_d = ST_LISTEN;
      // receive role wins over a local request in the same window
      ST_LISTEN:    if (got_rts) state_d = ST_TX_CTS;
                    else if (tx_req_i) state_d = ST_SENSE;
                    else if (expire_i) state_d = ST_SLEEP;
      ST_SENSE:     if (busy_i) state_d = ST_DEFER;
                    else if (expire_i) state_d = ST_TX_RTS;
      ST_DEFER:     if (expire_i) state_d = tx_req_i ? ST_SENSE : ST_LISTEN;
      ST_TX_RTS:    state_d = ST_RTS_WAIT;
      ST_RTS_WAIT:  if (got_cts) state_d = ST_TX_DATA;
                    else if (expire_i) state_d = ST_RTS_GAP;
      ST_RTS_GAP:   if (expire_i) state_d = rts_reached_i ? ST_FAIL : ST_TX_RTS;
      ST_TX_DATA:   state_d = ST_ACK_WAIT;
      ST_ACK_WAIT:  if (got_ack) state_d = ST_DONE;
                    else if (expire_i) state_d = ST_FAIL;
      ST_TX_CTS:    state_d = ST_DATA_WAIT;
      ST_DATA_WAIT: if (got_data) state_d = ST_TX_ACK;
                    else if (expire_i) state_d = ST_SLEEP;
      ST_TX_ACK, ST_DONE, ST_FAIL: state_d = ST_SLEEP;
      default:      state_d = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SLEEP;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign timer_clr_o = (state_d != state_q);
  assign rts_clr_o   = (state_q == ST_SENSE);
  assign rts_inc_o   = (state_q == ST_TX_RTS);
endmodule

// File: rtl/tx_init_mac.sv
`timescale 1ns/1ps
module tx_init_mac
  import mac_pkg::*;
#(
  parameter int TW = 16,
  parameter int RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          busy_i,
  input  logic          tx_req_i,
  input  logic          rx_valid_i,
  input  logic [1:0]    rx_type_i,
  input  logic [TW-1:0] cfg_period_i,
  input  logic [TW-1:0] cfg_on_i,
  input  logic [TW-1:0] cfg_listen_i,
  input  logic [TW-1:0] cfg_gap_i,
  input  logic [RW-1:0] cfg_max_rts_i,
  input  logic [TW-1:0] cfg_timeout_i,
  output logic          radio_en_o,
  output logic          send_valid_o,
  output logic [1:0]    send_type_o,
  output logic          done_o,
  output logic          fail_o
);
  mac_state_e    fsm_state;
  logic [TW-1:0] win_limit;
  logic          win_expire, win_clr;
  logic          rts_clr, rts_inc, rts_reached;

  mac_window_sel #(.TW(TW)) i_window_sel (
    .state_i  (fsm_state),
    .period_i (cfg_period_i),
    .on_i     (cfg_on_i),
    .listen_i (cfg_listen_i),
    .gap_i    (cfg_gap_i),
    .timeout_i(cfg_timeout_i),
    .limit_o  (win_limit)
  );

  mac_tick_timer #(.TW(TW)) i_tick_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (win_clr),
    .tick_i  (tick_i),
    .limit_i (win_limit),
    .expire_o(win_expire)
  );

  mac_rts_counter #(.RW(RW)) i_rts_counter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rts_clr),
    .inc_i    (rts_inc),
    .max_i    (cfg_max_rts_i),
    .reached_o(rts_reached)
  );

  mac_fsm i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .expire_i     (win_expire),
    .tx_req_i     (tx_req_i),
    .busy_i       (busy_i),
    .rx_valid_i   (rx_valid_i),
    .rx_type_i    (rx_type_i),
    .rts_reached_i(rts_reached),
    .state_o      (fsm_state),
    .timer_clr_o  (win_clr),
    .rts_clr_o    (rts_clr),
    .rts_inc_o    (rts_inc)
  );

  always_comb begin
    unique case (fsm_state)
      ST_SLEEP, ST_DEFER, ST_RTS_GAP, ST_DONE, ST_FAIL: radio_en_o = 1'b0;
      default: radio_en_o = 1'b1;
    endcase
  end

  always_comb begin
    send_valid_o = 1'b1;
    unique case (fsm_state)
      ST_TX_RTS:  send_type_o = FR_RTS;
      ST_TX_CTS:  send_type_o = FR_CTS;
      ST_TX_DATA: send_type_o = FR_DATA;
      ST_TX_ACK:  send_type_o = FR_ACK;
      default: begin
        send_valid_o = 1'b0;
        send_type_o  = FR_RTS;
      end
    endcase
  end

  assign done_o = (fsm_state == ST_DONE);
  assign fail_o = (fsm_state == ST_FAIL);
endmodule

// File: rtl/mac_checker.sv
`timescale 1ns/1ps
module mac_checker
  import mac_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input mac_state_e state_i,
  input logic       busy_i,
  input logic       rx_valid_i,
  input logic [1:0] rx_type_i,
  input logic       radio_en_o,
  input logic       send_valid_o,
  input logic [1:0] send_type_o,
  input logic       done_o,
  input logic       fail_o
);
  a_r13_one_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({send_valid_o, done_o, fail_o}));

  a_r10_cts_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LISTEN && rx_valid_i && rx_type_i == 2'd0)
      |=> (send_valid_o && send_type_o == 2'd1));

  a_r10_ack_reply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_DATA_WAIT && rx_valid_i && rx_type_i == 2'd2)
      |=> (send_valid_o && send_type_o == 2'd3));

  a_r7_data_after_cts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RTS_WAIT && rx_valid_i && rx_type_i == 2'd1)
      |=> (send_valid_o && send_type_o == 2'd2));

  a_r5_listen_after_rts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_o && send_type_o == 2'd0) |=> (radio_en_o && !send_valid_o));

  a_r4_busy_defers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SENSE && busy_i) |=> !radio_en_o);

  a_r8_done_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rx_valid_i && rx_type_i == 2'd3));

  a_r12_sleep_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SLEEP) |=> !send_valid_o);
endmodule

bind tx_init_mac mac_checker i_mac_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (fsm_state),
  .busy_i      (busy_i),
  .rx_valid_i  (rx_valid_i),
  .rx_type_i   (rx_type_i),
  .radio_en_o  (radio_en_o),
  .send_valid_o(send_valid_o),
  .send_type_o (send_type_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/test_tx_init_mac.sv
`timescale 1ns/1ps
module test_tx_init_mac;
  localparam int TW = 8;
  localparam int RW = 4;
  localparam int C_T = 6, C_ON = 2, C_TL = 2, C_TS = 3, C_MAX = 3, C_TO = 4;

  localparam int P_SLEEP = 0, P_LISTEN = 1, P_SENSE = 2, P_DEFER = 3, P_RTS = 4,
                 P_RTS_WAIT = 5, P_GAP = 6, P_DATA = 7, P_ACK_WAIT = 8, P_CTS = 9,
                 P_DATA_WAIT = 10, P_ACK = 11, P_DONE = 12, P_FAIL = 13;

  logic clk_i = 1'b0, rst_ni = 1'b1, tick_i = 1'b0, busy_i = 1'b0, tx_req_i = 1'b0;
  logic rx_valid_i = 1'b0;
  logic [1:0] rx_type_i = 2'd0;
  logic radio_en_o, send_valid_o, done_o, fail_o;
  logic [1:0] send_type_o;

  always #10 clk_i = ~clk_i;

  tx_init_mac #(.TW(TW), .RW(RW)) i_tx_init_mac (
    .clk_i, .rst_ni, .tick_i, .busy_i, .tx_req_i, .rx_valid_i, .rx_type_i,
    .cfg_period_i (TW'(C_T)),
    .cfg_on_i     (TW'(C_ON)),
    .cfg_listen_i (TW'(C_TL)),
    .cfg_gap_i    (TW'(C_TS)),
    .cfg_max_rts_i(RW'(C_MAX)),
    .cfg_timeout_i(TW'(C_TO)),
    .radio_en_o, .send_valid_o, .send_type_o, .done_o, .fail_o
  );

  int total = 0, bad = 0;
  int m_ph, m_rem, m_rts;
  int n_rts = 0, n_cts = 0, n_data = 0, n_ack = 0, n_done = 0, n_fail = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dur(input int p);
    case (p)
      P_SLEEP, P_DEFER:        return C_T - C_ON;
      P_LISTEN, P_SENSE:       return C_ON;
      P_RTS_WAIT:              return C_TL;
      P_GAP:                   return C_TS;
      P_ACK_WAIT, P_DATA_WAIT: return C_TO;
      default:                 return 1;
    endcase
  endfunction

  function automatic string tag_of(input int p);
    case (p)
      P_SLEEP, P_LISTEN:          return "R2";
      P_SENSE:                    return "R3";
      P_DEFER:                    return "R4";
      P_RTS, P_RTS_WAIT, P_GAP:   return "R5";
      P_FAIL:                     return "R6";
      P_DATA:                     return "R7";
      P_ACK_WAIT, P_DONE:         return "R8";
      default:                    return "R10";
    endcase
  endfunction

  // {radio, send_valid, send_type, done, fail}
  function automatic int expect_vec(input int p);
    case (p)
      P_SLEEP, P_DEFER, P_GAP: return 6'b000000;
      P_DONE:                  return 6'b000010;
      P_FAIL:                  return 6'b000001;
      P_RTS:                   return 6'b110000;
      P_CTS:                   return 6'b110100;
      P_DATA:                  return 6'b111000;
      P_ACK:                   return 6'b111100;
      default:                 return 6'b100000;
    endcase
  endfunction

  // reference model: phase plus remaining ticks
  always @(posedge clk_i or negedge rst_ni) begin : model
    int nx;
    bit ex;
    if (!rst_ni) begin
      m_ph = P_SLEEP; m_rem = C_T - C_ON; m_rts = 0;
    end else begin
      ex = tick_i && (m_rem == 1);
      nx = m_ph;
      case (m_ph)
        P_SLEEP:     if (tx_req_i) nx = P_SENSE; else if (ex) nx = P_LISTEN;
        P_LISTEN:    if (rx_valid_i && rx_type_i == 0) nx = P_CTS;
                     else if (tx_req_i) nx = P_SENSE; else if (ex) nx = P_SLEEP;
        P_SENSE:     if (busy_i) nx = P_DEFER; else if (ex) nx = P_RTS;
        P_DEFER:     if (ex) nx = tx_req_i ? P_SENSE : P_LISTEN;
        P_RTS:       begin nx = P_RTS_WAIT; m_rts++; end
        P_RTS_WAIT:  if (rx_valid_i && rx_type_i == 1) nx = P_DATA; else if (ex) nx = P_GAP;
        P_GAP:       if (ex) nx = (m_rts >= C_MAX) ? P_FAIL : P_RTS;
        P_DATA:      nx = P_ACK_WAIT;
        P_ACK_WAIT:  if (rx_valid_i && rx_type_i == 3) nx = P_DONE; else if (ex) nx = P_FAIL;
        P_CTS:       nx = P_DATA_WAIT;
        P_DATA_WAIT: if (rx_valid_i && rx_type_i == 2) nx = P_ACK; else if (ex) nx = P_SLEEP;
        default:     nx = P_SLEEP;
      endcase
      if (m_ph == P_SENSE) m_rts = 0;
      if (nx != m_ph) m_rem = dur(nx);
      else if (tick_i) m_rem--;
      m_ph = nx;
    end
  end

  always @(negedge clk_i) if (rst_ni) tick_i <= ~tick_i;

  // per-cycle comparison and event counting
  always @(negedge clk_i) begin
    if (rst_ni) begin
      check(tag_of(m_ph), int'({radio_en_o, send_valid_o, send_type_o, done_o, fail_o}),
            expect_vec(m_ph));
      check("R13", int'($countones({send_valid_o, done_o, fail_o}) <= 1), 1);
      if (send_valid_o) begin
        case (send_type_o)
          2'd0: n_rts++;
          2'd1: n_cts++;
          2'd2: n_data++;
          default: n_ack++;
        endcase
      end
      if (done_o) n_done++;
      if (fail_o) n_fail++;
    end
  end

  task automatic wait_ph(input int p, input string req);
    for (int i = 0; i < 400; i++) begin
      if (m_ph == p) return;
      @(negedge clk_i);
    end
    check(req, m_ph, p);
  endtask

  task automatic wait_status(input string req);
    for (int i = 0; i < 600; i++) begin
      if (done_o || fail_o) return;
      @(negedge clk_i);
    end
    check(req, 0, 1);
  endtask

  task automatic pulse(input logic [1:0] kind);
    rx_type_i = kind;
    rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin : stim
    int c0, c1, c2;
    #5 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 reset outputs", int'({radio_en_o, send_valid_o, done_o, fail_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 sleeps after reset", int'(radio_en_o), 0);
    repeat (40) @(negedge clk_i);  // R2 idle cycling

    // R12: RTS while asleep is ignored
    wait_ph(P_SLEEP, "R12");
    c0 = n_cts;
    pulse(2'd0);
    repeat (4) @(negedge clk_i);
    check("R12 no reply in sleep", n_cts - c0, 0);

    // R10: receiver role, full reply
    wait_ph(P_LISTEN, "R10");
    c0 = n_cts; c1 = n_ack;
    pulse(2'd0);
    wait_ph(P_DATA_WAIT, "R10");
    pulse(2'd2);
    repeat (3) @(negedge clk_i);
    check("R10 cts sent", n_cts - c0, 1);
    check("R10 ack sent", n_ack - c1, 1);

    // R11: no DATA after CTS
    wait_ph(P_LISTEN, "R11");
    c1 = n_ack;
    pulse(2'd0);
    repeat (12) @(negedge clk_i);
    check("R11 radio off after timeout", int'(radio_en_o), 0);
    check("R11 no ack", n_ack - c1, 0);

    // R3/R7/R8: sender success
    wait_ph(P_SLEEP, "R3");
    c0 = n_data; c1 = n_done;
    tx_req_i = 1'b1;
    @(negedge clk_i);
    check("R3 radio on for sense", int'(radio_en_o), 1);
    wait_ph(P_RTS_WAIT, "R5");
    pulse(2'd1);
    check("R7 data follows cts", int'({send_valid_o, send_type_o}), 3'b110);
    wait_ph(P_ACK_WAIT, "R8");
    pulse(2'd3);
    wait_status("R8");
    check("R8 done pulse", int'(done_o), 1);
    tx_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R7 one data frame", n_data - c0, 1);
    check("R8 one done", n_done - c1, 1);

    // R4/R6: busy defer then unanswered retries
    wait_ph(P_SLEEP, "R4");
    c0 = n_rts; c1 = n_fail;
    busy_i = 1'b1;
    tx_req_i = 1'b1;
    wait_ph(P_DEFER, "R4");
    check("R4 radio off on defer", int'(radio_en_o), 0);
    busy_i = 1'b0;
    wait_status("R6");
    check("R6 fail pulse", int'(fail_o), 1);
    tx_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R6 rts count", n_rts - c0, C_MAX);
    check("R6 one fail", n_fail - c1, 1);

    // R9: ack timeout
    wait_ph(P_SLEEP, "R9");
    c1 = n_fail; c2 = n_done;
    tx_req_i = 1'b1;
    wait_ph(P_RTS_WAIT, "R9");
    pulse(2'd1);
    wait_status("R9");
    check("R9 fail on ack timeout", int'(fail_o), 1);
    tx_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R9 fail count", n_fail - c1, 1);
    check("R9 no done", n_done - c2, 0);

    repeat (20) @(negedge clk_i);
    finish_run();
  end
endmodule